// File: doc/BRIEF.md
# Multi-Element Indexed Register Bank

The block keeps a row of `DEPTH` registers, each `WIDTH` bits wide, and shows all of them at once on one parallel output bus. Every cycle it builds a candidate next value. It starts from the vector that is currently stored and replaces some elements with write data. The stored vector takes that candidate only on a clock edge where the write enable is high. At all other times it holds.

Two selection modes exist, and both can touch up to `RUN` elements in one cycle. In run mode a contiguous group of elements is replaced, starting at a start index given at runtime. In list mode each write lane carries its own explicit element position. A count input sets how many lanes take part. A broadcast flag copies lane 0 of the write data into every selected element. Positions that fall past the end of the bank are dropped, so a write never wraps around.

Top module: `idx_reg_bank`

## Requirements
- R1: Element positions are zero-based. Position 0 names element 0, which is driven on `bank_o[WIDTH-1:0]`. Element e is driven on `bank_o[e*WIDTH +: WIDTH]`.
- R2: In run mode (`mode_i` = 0), each lane l below the effective count writes write-data lane l (`wdata_i[l*WIDTH +: WIDTH]`) into element `start_i + l`. All other elements keep their values.
- R3: A bank holding 16, 17, 18, 19 (elements 0..3) takes a run-mode write of 20, 21 at start 0 with count 2, and then reads 20, 21, 18, 19.
- R4: When `wr_en_i` is low at a clock edge, `bank_o` does not change, whatever the other inputs are.
- R5: When `bcast_i` is 1, every selected element receives write-data lane 0 and the other lanes are ignored.
- R6: In list mode (`mode_i` = 1), each lane l below the effective count writes write-data lane l into the element named by `idx_list_i[l*IDX_W +: IDX_W]`.
- R7: A selected position of `DEPTH` or above is ignored. It neither wraps nor disturbs any element, and this holds in both modes.
- R8: If two active lanes in one list name the same element, the lane with the higher number sets its value.
- R9: While `rst_ni` is low, every element reads `INIT_VAL` (default 0). Reset is asynchronous.
- R10: A count `cnt_i` of 0 writes nothing. A count above `RUN` acts as `RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Commit the assembled vector at this edge |
| mode_i | input | 1 | 0 = run from start index, 1 = explicit position list |
| start_i | input | IDX_W | First element of the run in run mode |
| idx_list_i | input | RUN*IDX_W | Per-lane element positions in list mode, lane 0 in the low bits |
| cnt_i | input | $clog2(RUN+1) | Number of active lanes |
| bcast_i | input | 1 | Copy write-data lane 0 to every selected element |
| wdata_i | input | RUN*WIDTH | Write data, lane 0 in the low bits |
| bank_o | output | DEPTH*WIDTH | All stored elements, element 0 in the low bits |

## Verification
The stimulus table chains its writes, so each expected vector builds on the one before. The entries cover these cases:
- Full-width and two-element runs at start 0. These separate correct placement from an off-by-one or a reversed lane order.
- A run that crosses the top of the bank, and a run starting at position 15. These show whether overflow positions are dropped or wrap to element 0.
- List-mode entries with a scattered order, a repeated position and an out-of-range entry. These separate per-lane routing from run addressing and confirm that the last lane wins.
- Broadcast in both modes. This tells lane-0 replication apart from per-lane data.

Directed steps then apply a count of zero, a count above `RUN`, a disabled write and a reset in mid-operation.

// File: rtl/idx_reg_bank_pkg.sv
package idx_reg_bank_pkg;
  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_LIST = 1'b1
  } wr_mode_e;
endpackage

// File: rtl/rb_lane_addr.sv
// Per-lane target position and lane-active flag.
module rb_lane_addr
  import idx_reg_bank_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int RUN   = 4,
  parameter int IDX_W = 4,
  localparam int CNT_W = $clog2(RUN + 1),
  localparam int POS_W = IDX_W + $clog2(RUN + 1)
) (
  input  logic                       mode_i,
  input  logic [IDX_W-1:0]           start_i,
  input  logic [RUN*IDX_W-1:0]       idx_list_i,
  input  logic [CNT_W-1:0]           cnt_i,
  output logic [RUN-1:0][POS_W-1:0]  lane_pos_o,
  output logic [RUN-1:0]             lane_vld_o
);
  logic [CNT_W-1:0] cnt_eff;
  wr_mode_e         mode;

  assign mode    = wr_mode_e'(mode_i);
  assign cnt_eff = (cnt_i > CNT_W'(RUN)) ? CNT_W'(RUN) : cnt_i;

  for (genvar l = 0; l < RUN; l++) begin : g_lane
    logic [POS_W-1:0] pos;
    always_comb begin
      if (mode == MODE_LIST) pos = POS_W'(idx_list_i[l*IDX_W +: IDX_W]);
      else                   pos = POS_W'(start_i) + POS_W'(l);
    end
    assign lane_pos_o[l] = pos;
    // wide compare: positions past the bank never alias back
    assign lane_vld_o[l] = (CNT_W'(l) < cnt_eff) && (pos < POS_W'(DEPTH));
  end
endmodule

// File: rtl/rb_merge.sv
// Overlay active lanes on the current vector; highest lane wins.
module rb_merge #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  parameter int RUN   = 4,
  parameter int POS_W = 6
) (
  input  logic [RUN-1:0][POS_W-1:0]  lane_pos_i,
  input  logic [RUN-1:0]             lane_vld_i,
  input  logic                       bcast_i,
  input  logic [RUN*WIDTH-1:0]       wdata_i,
  input  logic [DEPTH*WIDTH-1:0]     cur_i,
  output logic [DEPTH*WIDTH-1:0]     nxt_o
);
  logic [RUN-1:0][WIDTH-1:0] lane_dat;

  for (genvar l = 0; l < RUN; l++) begin : g_dat
    assign lane_dat[l] = bcast_i ? wdata_i[WIDTH-1:0] : wdata_i[l*WIDTH +: WIDTH];
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_elem
    logic [WIDTH-1:0] val;
    always_comb begin
      val = cur_i[e*WIDTH +: WIDTH];
      for (int l = 0; l < RUN; l++) begin
        if (lane_vld_i[l] && (lane_pos_i[l] == POS_W'(e))) val = lane_dat[l];
      end
    end
    assign nxt_o[e*WIDTH +: WIDTH] = val;
  end
endmodule

// File: rtl/rb_store.sv
module rb_store #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] INIT_VAL = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic [DEPTH*WIDTH-1:0] d_i,
  output logic [DEPTH*WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= {DEPTH{INIT_VAL}};
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/idx_reg_bank.sv
module idx_reg_bank #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  parameter int RUN   = 4,
  parameter int IDX_W = 4,
  parameter logic [WIDTH-1:0] INIT_VAL = '0,
  localparam int CNT_W = $clog2(RUN + 1),
  localparam int POS_W = IDX_W + $clog2(RUN + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   mode_i,
  input  logic [IDX_W-1:0]       start_i,
  input  logic [RUN*IDX_W-1:0]   idx_list_i,
  input  logic [CNT_W-1:0]       cnt_i,
  input  logic                   bcast_i,
  input  logic [RUN*WIDTH-1:0]   wdata_i,
  output logic [DEPTH*WIDTH-1:0] bank_o
);
  logic [RUN-1:0][POS_W-1:0] lane_pos;
  logic [RUN-1:0]            lane_vld;
  logic [DEPTH*WIDTH-1:0]    nxt;

  rb_lane_addr #(.DEPTH(DEPTH), .RUN(RUN), .IDX_W(IDX_W)) u_addr (
    .mode_i     (mode_i),
    .start_i    (start_i),
    .idx_list_i (idx_list_i),
    .cnt_i      (cnt_i),
    .lane_pos_o (lane_pos),
    .lane_vld_o (lane_vld)
  );

  rb_merge #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RUN(RUN), .POS_W(POS_W)) u_merge (
    .lane_pos_i (lane_pos),
    .lane_vld_i (lane_vld),
    .bcast_i    (bcast_i),
    .wdata_i    (wdata_i),
    .cur_i      (bank_o),
    .nxt_o      (nxt)
  );

  rb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .INIT_VAL(INIT_VAL)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wr_en_i),
    .d_i    (nxt),
    .q_o    (bank_o)
  );
endmodule

// File: rtl/idx_reg_bank_chk.sv
// Requires DEPTH >= 2 and RUN >= 2.
module idx_reg_bank_chk #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  parameter int RUN   = 4,
  parameter int IDX_W = 4,
  localparam int CNT_W = $clog2(RUN + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_en_i,
  input logic                   mode_i,
  input logic [IDX_W-1:0]       start_i,
  input logic [CNT_W-1:0]       cnt_i,
  input logic                   bcast_i,
  input logic [RUN*WIDTH-1:0]   wdata_i,
  input logic [DEPTH*WIDTH-1:0] bank_o
);
  // R4
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(bank_o));

  // R10
  zero_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && cnt_i == '0) |=> $stable(bank_o));

  // R7
  start_past_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !mode_i && (int'(start_i) >= DEPTH)) |=> $stable(bank_o));

  // R1 R2
  first_elem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !mode_i && start_i == '0 && cnt_i != '0 && !bcast_i)
    |=> bank_o[WIDTH-1:0] == $past(wdata_i[WIDTH-1:0]));

  // R5
  bcast_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !mode_i && start_i == '0 && cnt_i >= CNT_W'(2) && bcast_i)
    |=> bank_o[2*WIDTH-1:WIDTH] == $past(wdata_i[WIDTH-1:0]));
endmodule

bind idx_reg_bank idx_reg_bank_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .RUN(RUN), .IDX_W(IDX_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .mode_i  (mode_i),
  .start_i (start_i),
  .cnt_i   (cnt_i),
  .bcast_i (bcast_i),
  .wdata_i (wdata_i),
  .bank_o  (bank_o)
);

// File: tb/idx_reg_bank_test.sv
`timescale 1ns/1ps
module idx_reg_bank_test;
  localparam int DEPTH = 4, WIDTH = 8, RUN = 4, IDX_W = 4, CNT_W = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0, mode_i = 1'b0, bcast_i = 1'b0;
  logic [IDX_W-1:0]       start_i = '0;
  logic [RUN*IDX_W-1:0]   idx_list_i = '0;
  logic [CNT_W-1:0]       cnt_i = '0;
  logic [RUN*WIDTH-1:0]   wdata_i = '0;
  logic [DEPTH*WIDTH-1:0] bank_o;

  always #2 clk_i = ~clk_i;

  idx_reg_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RUN(RUN), .IDX_W(IDX_W)) uut (.*);

  typedef struct packed {
    logic [7:0]  req;
    logic        mode;
    logic        bcast;
    logic [2:0]  cnt;
    logic [3:0]  start;
    logic [15:0] list;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  // Chained: each row starts from the previous row's result.
  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{8'd2,  1'b0, 1'b0, 3'd4, 4'd0,  16'h0000, 32'h13121110, 32'h13121110}, // R2 R1 load 16..19
    '{8'd3,  1'b0, 1'b0, 3'd2, 4'd0,  16'h0000, 32'hEEEE1514, 32'h13121514}, // R3
    '{8'd7,  1'b0, 1'b0, 3'd4, 4'd2,  16'h0000, 32'h33323130, 32'h31301514}, // R7 run past top
    '{8'd2,  1'b0, 1'b0, 3'd1, 4'd1,  16'h0000, 32'hDDDDDD40, 32'h31304014}, // R2 single
    '{8'd5,  1'b0, 1'b1, 3'd2, 4'd1,  16'h0000, 32'hEEEEEE55, 32'h31555514}, // R5 run bcast
    '{8'd6,  1'b1, 1'b0, 3'd3, 4'd0,  16'h0903, 32'hAA636261, 32'h61555562}, // R6 R7 list
    '{8'd8,  1'b1, 1'b0, 3'd2, 4'd0,  16'h0022, 32'h00007170, 32'h61715562}, // R8 duplicate
    '{8'd5,  1'b1, 1'b1, 3'd4, 4'd0,  16'h0F31, 32'hBBBBBB0A, 32'h0A710A0A}, // R5 list bcast
    '{8'd10, 1'b0, 1'b0, 3'd0, 4'd0,  16'h0000, 32'hFFFFFFFF, 32'h0A710A0A}, // R10 zero count
    '{8'd10, 1'b0, 1'b0, 3'd7, 4'd0,  16'h0000, 32'h04030201, 32'h04030201}, // R10 clamp
    '{8'd7,  1'b0, 1'b0, 3'd4, 4'd15, 16'h0000, 32'h99999999, 32'h04030201}, // R7 no wrap
    '{8'd6,  1'b1, 1'b0, 3'd4, 4'd0,  16'h0123, 32'h44434241, 32'h41424344}  // R6 reversed list
  };

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: bank_o=%h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(9, bank_o, 32'h0); // R9 held in reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(9, bank_o, 32'h0); // R9 after release
    for (int i = 0; i < NV; i++) begin
      wr_en_i = 1'b1; mode_i = TBL[i].mode; bcast_i = TBL[i].bcast;
      cnt_i = TBL[i].cnt; start_i = TBL[i].start; idx_list_i = TBL[i].list;
      wdata_i = TBL[i].wdata;
      @(negedge clk_i);
      check(int'(TBL[i].req), bank_o, TBL[i].exp);
    end
    // R4: disabled write with live data
    wr_en_i = 1'b0; mode_i = 1'b0; cnt_i = 3'd4; start_i = 4'd0; wdata_i = 32'h77777777;
    @(negedge clk_i);
    check(4, bank_o, 32'h41424344);
    @(negedge clk_i);
    check(4, bank_o, 32'h41424344);
    // R1: element 0 alone at position 0 via list
    wr_en_i = 1'b1; mode_i = 1'b1; cnt_i = 3'd1; idx_list_i = 16'h0000; wdata_i = 32'h000000C3;
    @(negedge clk_i);
    check(1, bank_o, 32'h414243C3);
    // R9: asynchronous reset mid-cycle
    wr_en_i = 1'b0;
    #1 rst_ni = 1'b0;
    #0.5 check(9, bank_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(9, bank_o, 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk_i);
        fails++; checks++;
        $display("FAIL watchdog: done=0 expected 1");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule